// File: doc/BRIEF.md
# Cascaded Static-Priority Tree Selector

This block chooses which waiting entries of an instruction queue may leave in the current cycle. It takes a request vector with one bit per entry and returns, for each of several execution ways of the same kind, a one-hot grant vector. The choice always favours the lowest-numbered requesting entry. Inside each way, the selector is a tree of four-input nodes. Each node reports upward whether any of its inputs is requesting. Each node also passes an enable back down to exactly one requesting input, and it does so only when the enable from above is set.

Several ways are served by a chain of trees. The first tree sees the raw request vector. Each later tree sees that vector with every entry granted by the earlier trees removed, so no entry is granted twice in a cycle. Each way's root enable is its "unit available" input. When that input is low, the way grants nothing, and its would-be winner stays eligible for the next way in the chain.

Each entry may carry a destination tag. The tag of each node's winning input is steered toward the root, so every way presents the tag of the entry it granted. The whole block is combinational. It is meant to sit inside a single cycle, between forming the request vector and marking the winners as scheduled.

Top module: `sel_cascade`

## Requirements
- R1: Each way's grant field (entry i of way w at bit w*ENTRIES+i of `grant_o`) has at most one bit set.
- R2: With no entry requesting, every grant bit, every valid bit and every tag output is zero.
- R3: When way 0 is available and any entry requests, way 0 grants the lowest-numbered requesting entry.
- R4: Way w grants the lowest-numbered requesting entry not granted by ways 0..w-1, so grants of different ways never overlap.
- R5: A way whose available bit is low grants nothing, and the entry it would have taken remains eligible for later ways.
- R6: `grant_vld_o[w]` is high exactly when way w's grant field is nonzero.
- R7: `tag_o` bits w*TAG_W upward carry the tag of the entry way w granted (entry i's tag at `tag_i` bits i*TAG_W upward), and are zero when way w grants nothing.
- R8: With fewer requesting entries than available ways, only the first ways in order receive grants, and the rest stay silent.
- R9: Outputs follow inputs within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_i | input | ENTRIES (16) | One request bit per queue entry |
| tag_i | input | ENTRIES*TAG_W (96) | Destination tag per entry, entry i at bits i*TAG_W |
| avail_i | input | WAYS (3) | Per-way root enable (execution unit can accept) |
| grant_o | output | WAYS*ENTRIES (48) | One-hot grant per way, way w at bits w*ENTRIES |
| grant_vld_o | output | WAYS (3) | Way w granted some entry |
| tag_o | output | WAYS*TAG_W (18) | Tag of the entry granted to each way |

## Verification
The hardest situation to reach is an unavailable way in the middle of the chain. In that case the entry the way would have taken must be handed on to a later way, and the masked request vector must skip exactly the earlier winners. The stimulus table therefore pairs sparse request patterns, with entries spread across different leaf nodes, with every interesting combination of the available bits. A sweep of single-entry requests drives each leaf position through both tree levels. A mid-cycle change of the request vector shows that the grants settle before the next edge.

// File: rtl/sel_pkg.sv
package sel_pkg;

  // Offset of the first node of a tree level in a flat per-level vector.
  // Level 0 holds the leaf entries, level LEVELS holds the root output.
  function automatic int unsigned lvl_off(input int unsigned levels,
                                          input int unsigned lvl);
    int unsigned acc;
    acc = 0;
    for (int unsigned k = 0; k < lvl; k++) begin
      acc += 4 ** (levels - k);
    end
    return acc;
  endfunction

endpackage

// File: rtl/sel_node4.sv
module sel_node4 #(
  parameter int unsigned TAG_W     = 6,
  parameter bit          CARRY_TAG = 1'b1
) (
  input  logic [3:0]         req_i,
  input  logic               gnt_i,
  input  logic [4*TAG_W-1:0] tag_i,
  output logic [3:0]         gnt_o,
  output logic               req_o,
  output logic [TAG_W-1:0]   tag_o
);

  logic [3:0] first;

  // Fixed priority: input 0 highest.
  always_comb begin
    first[0] = req_i[0];
    first[1] = req_i[1] & ~req_i[0];
    first[2] = req_i[2] & ~|req_i[1:0];
    first[3] = req_i[3] & ~|req_i[2:0];
  end

  assign gnt_o = first & {4{gnt_i}};
  assign req_o = |req_i;

  generate
    if (CARRY_TAG) begin : g_tag
      always_comb begin
        tag_o = '0;
        for (int i = 0; i < 4; i++) begin
          if (first[i]) tag_o = tag_i[i*TAG_W +: TAG_W];
        end
      end
    end else begin : g_notag
      assign tag_o = '0;
    end
  endgenerate

endmodule

// File: rtl/sel_tree.sv
module sel_tree
  import sel_pkg::*;
#(
  parameter int unsigned LEVELS    = 2,
  parameter int unsigned TAG_W     = 6,
  parameter bit          CARRY_TAG = 1'b1
) (
  input  logic [4**LEVELS-1:0]       req_i,
  input  logic [4**LEVELS*TAG_W-1:0] tag_i,
  input  logic                       avail_i,
  output logic [4**LEVELS-1:0]       gnt_o,
  output logic                       any_o,
  output logic [TAG_W-1:0]           tag_o
);

  localparam int unsigned ENTRIES = 4 ** LEVELS;
  localparam int unsigned TOTAL   = lvl_off(LEVELS, LEVELS + 1);
  localparam int unsigned ROOT    = TOTAL - 1;

  logic [TOTAL-1:0]       req_all;
  logic [TOTAL-1:0]       gnt_all;
  logic [TOTAL*TAG_W-1:0] tag_all;

  assign req_all[ENTRIES-1:0]         = req_i;
  assign tag_all[ENTRIES*TAG_W-1:0]   = tag_i;
  assign gnt_all[ROOT]                = avail_i;
  assign gnt_o                        = gnt_all[ENTRIES-1:0];
  assign any_o                        = req_all[ROOT];
  assign tag_o = (avail_i && req_all[ROOT]) ? tag_all[ROOT*TAG_W +: TAG_W] : '0;

  generate
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      localparam int unsigned IN_OFF  = lvl_off(LEVELS, l);
      localparam int unsigned OUT_OFF = lvl_off(LEVELS, l + 1);
      localparam int unsigned NODES   = 4 ** (LEVELS - l - 1);
      for (genvar n = 0; n < NODES; n++) begin : g_node
        sel_node4 #(
          .TAG_W     (TAG_W),
          .CARRY_TAG (CARRY_TAG)
        ) u_node (
          .req_i (req_all[IN_OFF + 4*n +: 4]),
          .gnt_i (gnt_all[OUT_OFF + n]),
          .tag_i (tag_all[(IN_OFF + 4*n)*TAG_W +: 4*TAG_W]),
          .gnt_o (gnt_all[IN_OFF + 4*n +: 4]),
          .req_o (req_all[OUT_OFF + n]),
          .tag_o (tag_all[(OUT_OFF + n)*TAG_W +: TAG_W])
        );
      end
    end
  endgenerate

endmodule

// File: rtl/sel_cascade.sv
module sel_cascade #(
  parameter int unsigned LEVELS    = 2,
  parameter int unsigned WAYS      = 3,
  parameter int unsigned TAG_W     = 6,
  parameter bit          CARRY_TAG = 1'b1
) (
  input  logic [4**LEVELS-1:0]       req_i,
  input  logic [4**LEVELS*TAG_W-1:0] tag_i,
  input  logic [WAYS-1:0]            avail_i,
  output logic [WAYS*4**LEVELS-1:0]  grant_o,
  output logic [WAYS-1:0]            grant_vld_o,
  output logic [WAYS*TAG_W-1:0]      tag_o
);

  localparam int unsigned ENTRIES = 4 ** LEVELS;

  // Request vector seen by each way after earlier winners are removed.
  logic [WAYS*ENTRIES-1:0] elig;
  logic [WAYS-1:0]         any;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      if (w == 0) begin : g_first
        assign elig[0 +: ENTRIES] = req_i;
      end else begin : g_later
        assign elig[w*ENTRIES +: ENTRIES] =
          elig[(w-1)*ENTRIES +: ENTRIES] & ~grant_o[(w-1)*ENTRIES +: ENTRIES];
      end

      sel_tree #(
        .LEVELS    (LEVELS),
        .TAG_W     (TAG_W),
        .CARRY_TAG (CARRY_TAG)
      ) u_tree (
        .req_i   (elig[w*ENTRIES +: ENTRIES]),
        .tag_i   (tag_i),
        .avail_i (avail_i[w]),
        .gnt_o   (grant_o[w*ENTRIES +: ENTRIES]),
        .any_o   (any[w]),
        .tag_o   (tag_o[w*TAG_W +: TAG_W])
      );

      assign grant_vld_o[w] = any[w] & avail_i[w];
    end
  endgenerate

endmodule

// File: rtl/sel_cascade_chk.sv
module sel_cascade_chk #(
  parameter int unsigned LEVELS = 2,
  parameter int unsigned WAYS   = 3,
  parameter int unsigned TAG_W  = 6
) (
  input logic [4**LEVELS-1:0]       req_i,
  input logic [4**LEVELS*TAG_W-1:0] tag_i,
  input logic [WAYS-1:0]            avail_i,
  input logic [WAYS*4**LEVELS-1:0]  grant_o,
  input logic [WAYS-1:0]            grant_vld_o,
  input logic [WAYS*TAG_W-1:0]      tag_o
);

  localparam int unsigned E = 4 ** LEVELS;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      a_r1_onehot: assert ($onehot0(grant_o[w*E +: E]))
        else $error("R1 way %0d grant not one-hot", w);
      a_r4_subset: assert ((grant_o[w*E +: E] & ~req_i) == '0)
        else $error("R4 way %0d grants non-requesting entry", w);
      a_r5_unavail: assert (avail_i[w] || grant_o[w*E +: E] == '0)
        else $error("R5 unavailable way %0d granted", w);
      a_r6_valid: assert (grant_vld_o[w] == (|grant_o[w*E +: E]))
        else $error("R6 way %0d valid mismatch", w);
      a_r7_tag_idle: assert (grant_vld_o[w] || tag_o[w*TAG_W +: TAG_W] == '0)
        else $error("R7 way %0d tag not zero while idle", w);
      for (int i = 0; i < E; i++) begin
        a_r7_tag_match: assert (!grant_o[w*E + i] ||
                                tag_o[w*TAG_W +: TAG_W] == tag_i[i*TAG_W +: TAG_W])
          else $error("R7 way %0d tag mismatch for entry %0d", w, i);
      end
      for (int v = w + 1; v < WAYS; v++) begin
        a_r4_distinct: assert ((grant_o[w*E +: E] & grant_o[v*E +: E]) == '0)
          else $error("R4 ways %0d and %0d share a grant", w, v);
      end
    end
    a_r2_idle: assert (req_i != '0 || (grant_o == '0 && grant_vld_o == '0))
      else $error("R2 grant with no request");
    a_r3_lowest: assert (!avail_i[0] || req_i == '0 ||
                         grant_o[E-1:0] == (req_i & (~req_i + 1'b1)))
      else $error("R3 way 0 did not take lowest entry");
  end

endmodule

bind sel_cascade sel_cascade_chk #(
  .LEVELS (LEVELS),
  .WAYS   (WAYS),
  .TAG_W  (TAG_W)
) chk_i (
  .req_i       (req_i),
  .tag_i       (tag_i),
  .avail_i     (avail_i),
  .grant_o     (grant_o),
  .grant_vld_o (grant_vld_o),
  .tag_o       (tag_o)
);

// File: tb/sel_cascade_tb_top.sv
module sel_cascade_tb_top;

  localparam int unsigned LEVELS = 2;
  localparam int unsigned WAYS   = 3;
  localparam int unsigned TAG_W  = 6;
  localparam int unsigned E      = 4 ** LEVELS;
  localparam int unsigned NONE   = 16;
  localparam int unsigned NVEC   = 12;

  logic clk;
  logic rst_n;
  logic [E-1:0]          req_i;
  logic [E*TAG_W-1:0]    tag_i;
  logic [WAYS-1:0]       avail_i;
  logic [WAYS*E-1:0]     grant_o;
  logic [WAYS-1:0]       grant_vld_o;
  logic [WAYS*TAG_W-1:0] tag_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // {request, avail (bit w = way w), expected entry for way 0, 1, 2}; 16 = none
  localparam logic [33:0] VEC [NVEC] = '{
    {16'h0000, 3'b111, 5'd16, 5'd16, 5'd16},
    {16'h0001, 3'b111, 5'd0,  5'd16, 5'd16},
    {16'h8000, 3'b111, 5'd15, 5'd16, 5'd16},
    {16'hFFFF, 3'b111, 5'd0,  5'd1,  5'd2 },
    {16'h8421, 3'b111, 5'd0,  5'd5,  5'd10},
    {16'h8421, 3'b110, 5'd16, 5'd0,  5'd5 },
    {16'h8421, 3'b101, 5'd0,  5'd16, 5'd5 },
    {16'h00F0, 3'b000, 5'd16, 5'd16, 5'd16},
    {16'h1010, 3'b111, 5'd4,  5'd12, 5'd16},
    {16'h0300, 3'b011, 5'd8,  5'd9,  5'd16},
    {16'hC000, 3'b111, 5'd14, 5'd15, 5'd16},
    {16'h0008, 3'b100, 5'd16, 5'd16, 5'd3 }
  };

  sel_cascade #(
    .LEVELS (LEVELS),
    .WAYS   (WAYS),
    .TAG_W  (TAG_W)
  ) dut_i (
    .req_i       (req_i),
    .tag_i       (tag_i),
    .avail_i     (avail_i),
    .grant_o     (grant_o),
    .grant_vld_o (grant_vld_o),
    .tag_o       (tag_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic check_way(input int w, input int idx, input string rq);
    logic [E-1:0]     eg;
    logic [TAG_W-1:0] et;
    eg = (idx == NONE) ? '0 : (E'(1) << idx);
    et = (idx == NONE) ? '0 : (TAG_W'(idx) ^ 6'h2A);
    check(rq, $sformatf("way %0d grant", w), 64'(grant_o[w*E +: E]), 64'(eg));
    check("R6", $sformatf("way %0d valid", w), 64'(grant_vld_o[w]), 64'(idx != NONE));
    check("R7", $sformatf("way %0d tag", w), 64'(tag_o[w*TAG_W +: TAG_W]), 64'(et));
    check("R1", $sformatf("way %0d ones", w), 64'($countones(grant_o[w*E +: E])),
          64'(idx != NONE));
  endtask

  task automatic apply(input logic [E-1:0] r, input logic [WAYS-1:0] a,
                       input int e0, input int e1, input int e2, input string rq);
    @(posedge clk);
    req_i   = r;
    avail_i = a;
    @(negedge clk);
    check_way(0, e0, (rq == "") ? "R3" : rq);
    check_way(1, e1, (rq == "") ? "R4" : rq);
    check_way(2, e2, (rq == "") ? "R4" : rq);
  endtask

  initial begin
    rst_n   = 1'b0;
    req_i   = '0;
    avail_i = '0;
    for (int i = 0; i < E; i++) tag_i[i*TAG_W +: TAG_W] = TAG_W'(i) ^ 6'h2A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: quiet inputs give quiet outputs
    check("R2", "reset grants", 64'(grant_o), 64'd0);
    check("R2", "reset valid", 64'(grant_vld_o), 64'd0);
    check("R2", "reset tags", 64'(tag_o), 64'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      apply(VEC[v][33:18], VEC[v][17:15], int'(VEC[v][14:10]),
            int'(VEC[v][9:5]), int'(VEC[v][4:0]), "");
    end

    // R3, R8: single requester at every leaf position
    for (int i = 0; i < E; i++) begin
      apply(E'(1) << i, 3'b111, i, NONE, NONE, "R8");
    end

    // R5: no way available, full request
    apply(16'hFFFF, 3'b000, NONE, NONE, NONE, "R5");
    // R5: only last way available takes the lowest entry
    apply(16'h0660, 3'b100, NONE, NONE, 5, "R5");

    // R9: change inputs between edges, outputs follow before next edge
    @(posedge clk);
    req_i   = 16'h0042;
    avail_i = 3'b111;
    #0.5;
    check("R9", "way 0 same cycle", 64'(grant_o[0 +: E]), 64'h0002);
    req_i = 16'h0040;
    #0.5;
    check("R9", "way 0 after change", 64'(grant_o[0 +: E]), 64'h0040);
    check("R9", "way 1 after change", 64'(grant_o[E +: E]), 64'h0000);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule